// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pair Issue Control

This block sits at the issue point of a two-wide in-order pipeline. Every cycle it may be offered one 64-bit fetch word carrying two 32-bit instructions. The upper half is the first instruction in program order and is meant for the integer side of the machine; the integer side includes every load and store. The lower half is the second instruction and is meant for the floating-point arithmetic side. The block decides whether none, one or both instructions leave this cycle. It also tells the fetch side whether to present the same word again.

Pairing is one-sided. The second instruction can go only alongside the first, and only when the first is integer-class and the second is an FP operation. A load's result cannot be consumed by the instruction beside it, nor by either instruction of the following cycle. The load delay is one cycle, so it covers three instruction positions.

When the second instruction cannot go with the first, it is parked in a one-entry buffer. It then issues by itself on the first output before any new word is taken. If the first instruction has to wait for a load, nothing issues and the fetch word is held.

Top module: `pair_issue_ctl`

## Requirements
- R1: After reset, with `fetch_valid` low and nothing parked, `issue0_vld`, `issue1_vld` and `fetch_hold` are all 0.
- R2: The opcode is bits [31:26] and the class is taken from it:
  - 6'h23 is an integer load that writes the integer register in bits [20:16].
  - 6'h31 is an FP load that writes the FP register in bits [20:16].
  - 6'h2B is an integer store that reads integer registers [25:21] and [20:16].
  - 6'h39 is an FP store that reads integer [25:21] and FP [20:16].
  - 6'h11 is the only FP-class code and reads FP [25:21] and [20:16].
  - Every other code is integer arithmetic and reads integer [25:21] and [20:16].
  - Loads read only integer [25:21].
- R3: When no instruction is parked, the upper word half appears on `issue0_instr` and the lower half on `issue1_instr`. A legal, independent pair issues both in the same cycle, and the word is consumed (`fetch_hold` low).
- R4: `issue1_vld` is never high unless `issue0_vld` is high in the same cycle.
- R5: If the upper instruction is FP-class, or the lower one is not FP-class, only the upper instruction issues and the lower one is parked.
- R6: A load in the upper half whose destination is read by the lower instruction (same register file, same number) keeps the lower one from issuing; it is parked. An FP load paired with an independent FP operation issues as a pair.
- R7: An instruction that reads the destination of a load issued in the previous cycle does not issue this cycle.
- R8: A parked instruction appears alone on `issue0_instr`. While anything is parked, `fetch_hold` is high and no new word is taken. The parked instruction obeys R7.
- R9: When the upper instruction of a fresh word cannot issue, neither instruction issues and `fetch_hold` is high. The pair goes once the load delay has passed.
- R10: A load result collides only with a reader in the same register file. An integer load never blocks an FP operation with the same register number.
- R11: A cycle without an issue ends the load delay. After one idle cycle, a reader of the loaded register issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch word is offered this cycle |
| fetch_word | input | 64 | Upper half first instruction, lower half second |
| fetch_hold | output | 1 | The offered word is not consumed; present it again |
| issue0_vld | output | 1 | First issue position carries an instruction |
| issue0_instr | output | 32 | Instruction in the first issue position |
| issue1_vld | output | 1 | Second issue position carries an instruction |
| issue1_instr | output | 32 | Instruction in the second issue position |

## Verification
The bench aims at the three places a load's result is visible:
- the FP instruction beside it;
- both halves of the next word;
- a parked instruction that issues the cycle after its partner load.

A design that left out one of these windows would issue a reader a cycle early. One that made the window too long would stall a pair that is actually free. Cross-file collisions also get attention, with integer and FP registers of equal number, because a design that compared only numbers would stall needlessly. Misplaced or wrong-class pairs, and a long pseudo-random instruction stream, show whether a parked instruction is ever lost, duplicated or overtaken by the next fetch word.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int FETCH_W = 2 * INSTR_W;
    localparam int RS_HI   = INSTR_W - OP_W - 1;
    localparam int RT_HI   = RS_HI - REG_W;

    localparam logic [OP_W-1:0] OPC_LD_INT = 6'h23;
    localparam logic [OP_W-1:0] OPC_LD_FP  = 6'h31;
    localparam logic [OP_W-1:0] OPC_ST_INT = 6'h2B;
    localparam logic [OP_W-1:0] OPC_ST_FP  = 6'h39;
    localparam logic [OP_W-1:0] OPC_FPU    = 6'h11;

    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [REG_W-1:0]   reg_t;

    // decoded view of one instruction
    typedef struct packed {
        logic fp_class;
        logic is_load;
        logic dst_fp;
        reg_t dst;
        logic src1_fp;
        reg_t src1;
        logic src2_used;
        logic src2_fp;
        reg_t src2;
    } dec_t;

    // load issued in the previous cycle
    typedef struct packed {
        logic vld;
        logic fp;
        reg_t r;
    } ldtag_t;

    typedef struct packed {
        logic   held_vld;
        instr_t held;
        ldtag_t ld;
    } state_t;

    function automatic dec_t decode_instr(input instr_t i);
        dec_t d;
        logic [OP_W-1:0] op;
        op          = i[INSTR_W-1 -: OP_W];
        d.fp_class  = 1'b0;
        d.is_load   = 1'b0;
        d.dst_fp    = 1'b0;
        d.dst       = i[RT_HI -: REG_W];
        d.src1_fp   = 1'b0;
        d.src1      = i[RS_HI -: REG_W];
        d.src2_used = 1'b1;
        d.src2_fp   = 1'b0;
        d.src2      = i[RT_HI -: REG_W];
        case (op)
            OPC_LD_INT: begin
                d.is_load   = 1'b1;
                d.src2_used = 1'b0;
            end
            OPC_LD_FP: begin
                d.is_load   = 1'b1;
                d.dst_fp    = 1'b1;
                d.src2_used = 1'b0;
            end
            OPC_ST_FP: d.src2_fp = 1'b1;
            OPC_FPU: begin
                d.fp_class = 1'b1;
                d.src1_fp  = 1'b1;
                d.src2_fp  = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

    function automatic ldtag_t load_tag(input logic issued, input dec_t d);
        ldtag_t t;
        t.vld = issued & d.is_load;
        t.fp  = d.dst_fp;
        t.r   = d.dst;
        return t;
    endfunction

    function automatic logic load_hit(input ldtag_t t, input dec_t d);
        logic h1;
        logic h2;
        h1 = (d.src1 == t.r) && (d.src1_fp == t.fp);
        h2 = d.src2_used && (d.src2 == t.r) && (d.src2_fp == t.fp);
        return t.vld && (h1 || h2);
    endfunction

endpackage

// File: rtl/pair_issue_dec.sv
module pair_issue_dec
    import pair_issue_pkg::*;
(
    input  instr_t instr,
    output dec_t   dec
);
    always_comb dec = decode_instr(instr);
endmodule

// File: rtl/pair_issue_ldcmp.sv
module pair_issue_ldcmp
    import pair_issue_pkg::*;
(
    input  ldtag_t tag,
    input  dec_t   consumer,
    output logic   hit
);
    always_comb hit = load_hit(tag, consumer);
endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
    import pair_issue_pkg::*;
#(
    parameter int N_DEC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_valid,
    input  logic [FETCH_W-1:0] fetch_word,
    output logic               fetch_hold,
    output logic               issue0_vld,
    output logic [INSTR_W-1:0] issue0_instr,
    output logic               issue1_vld,
    output logic [INSTR_W-1:0] issue1_instr
);
    localparam int D_HELD  = 0;
    localparam int D_LEFT  = 1;
    localparam int D_RIGHT = 2;

    state_t st_q, st_d;
    instr_t src_a [N_DEC];
    dec_t   dec_a [N_DEC];
    ldtag_t left_tag;
    logic   hit_held_prev, hit_left_prev, hit_right_prev, hit_right_left;

    always_comb begin
        src_a[D_HELD]  = st_q.held;
        src_a[D_LEFT]  = fetch_word[FETCH_W-1 -: INSTR_W];
        src_a[D_RIGHT] = fetch_word[INSTR_W-1:0];
    end

    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        pair_issue_dec u_dec (.instr(src_a[g]), .dec(dec_a[g]));
    end

    always_comb left_tag = load_tag(1'b1, dec_a[D_LEFT]);

    pair_issue_ldcmp u_cmp_held  (.tag(st_q.ld),  .consumer(dec_a[D_HELD]),  .hit(hit_held_prev));
    pair_issue_ldcmp u_cmp_left  (.tag(st_q.ld),  .consumer(dec_a[D_LEFT]),  .hit(hit_left_prev));
    pair_issue_ldcmp u_cmp_right (.tag(st_q.ld),  .consumer(dec_a[D_RIGHT]), .hit(hit_right_prev));
    pair_issue_ldcmp u_cmp_pair  (.tag(left_tag), .consumer(dec_a[D_RIGHT]), .hit(hit_right_left));

    always_comb begin
        st_d         = st_q;
        st_d.ld      = '0;
        fetch_hold   = 1'b0;
        issue0_vld   = 1'b0;
        issue1_vld   = 1'b0;
        issue0_instr = src_a[D_LEFT];
        issue1_instr = src_a[D_RIGHT];
        if (st_q.held_vld) begin
            // parked instruction drains alone, fetch word waits
            fetch_hold   = 1'b1;
            issue0_instr = st_q.held;
            if (!hit_held_prev) begin
                issue0_vld    = 1'b1;
                st_d.held_vld = 1'b0;
                st_d.ld       = load_tag(1'b1, dec_a[D_HELD]);
            end
        end else if (fetch_valid) begin
            if (hit_left_prev) begin
                fetch_hold = 1'b1;
            end else begin
                issue0_vld = 1'b1;
                st_d.ld    = left_tag;
                if (!dec_a[D_LEFT].fp_class && dec_a[D_RIGHT].fp_class &&
                    !hit_right_left && !hit_right_prev) begin
                    issue1_vld = 1'b1;
                end else begin
                    st_d.held_vld = 1'b1;
                    st_d.held     = src_a[D_RIGHT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pair_issue_sva.sv
module pair_issue_sva
    import pair_issue_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_valid,
    input logic [FETCH_W-1:0] fetch_word,
    input logic               fetch_hold,
    input logic               issue0_vld,
    input logic [INSTR_W-1:0] issue0_instr,
    input logic               issue1_vld,
    input logic [INSTR_W-1:0] issue1_instr
);
    dec_t   d0, d1;
    ldtag_t prev_q;
    logic   parked_q;

    always_comb begin
        d0 = decode_instr(issue0_instr);
        d1 = decode_instr(issue1_instr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            parked_q <= 1'b0;
        end else begin
            prev_q   <= load_tag(issue0_vld, d0);
            parked_q <= fetch_valid && !fetch_hold && issue0_vld && !issue1_vld;
        end
    end

    // R4
    slot1_needs_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_vld |-> issue0_vld);

    // R5
    pair_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_vld |-> (!d0.fp_class && d1.fp_class));

    // R6
    same_pair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_vld |-> !load_hit(load_tag(1'b1, d0), d1));

    // R7
    next_pair_load0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue0_vld |-> !load_hit(prev_q, d0));

    // R7
    next_pair_load1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue1_vld |-> !load_hit(prev_q, d1));

    // R8
    parked_holds_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        parked_q |-> (fetch_hold && !issue1_vld));

    // R9
    stall_holds_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !issue0_vld) |-> fetch_hold);

endmodule

bind pair_issue_ctl pair_issue_sva i_sva (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .fetch_hold(fetch_hold), .issue0_vld(issue0_vld), .issue0_instr(issue0_instr),
    .issue1_vld(issue1_vld), .issue1_instr(issue1_instr)
);

// File: tb/test_pair_issue_ctl.sv
module test_pair_issue_ctl;

    typedef struct {
        bit          v;
        logic [63:0] w;
        string       tag;
    } ent_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        fetch_valid = 0;
    logic [63:0] fetch_word = '0;
    logic        fetch_hold, issue0_vld, issue1_vld;
    logic [31:0] issue0_instr, issue1_instr;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit run = 0;
    ent_t wq[$];
    string cur_tag = "R1";

    // model state
    bit          mh_v = 0;
    logic [31:0] mh = '0;
    bit          ml_v = 0;
    int          ml_r = 0;
    bit          ml_fp = 0;

    always #2 clk = ~clk;

    pair_issue_ctl i_pair_issue_ctl (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .fetch_hold(fetch_hold), .issue0_vld(issue0_vld), .issue0_instr(issue0_instr),
        .issue1_vld(issue1_vld), .issue1_instr(issue1_instr)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input int a, input int b);
        return {op, a[4:0], b[4:0], 16'h0};
    endfunction

    function automatic bit is_fpop(input logic [31:0] w);
        return w[31:26] == 6'h11;
    endfunction

    function automatic bit is_ld(input logic [31:0] w);
        return (w[31:26] == 6'h23) || (w[31:26] == 6'h31);
    endfunction

    // does w read register r of file fp (R2 table)?
    function automatic bit reads(input logic [31:0] w, input int r, input bit fp);
        int a, b;
        bit afp, bfp, buse;
        a = w[25:21]; b = w[20:16];
        afp = 0; bfp = 0; buse = 1;
        case (w[31:26])
            6'h23, 6'h31: buse = 0;
            6'h39: bfp = 1;
            6'h11: begin afp = 1; bfp = 1; end
            default: ;
        endcase
        return ((a == r) && (afp == fp)) || (buse && (b == r) && (bfp == fp));
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] up, input logic [31:0] lo, input string tag);
        ent_t e;
        e.v = 1; e.w = {up, lo}; e.tag = tag;
        wq.push_back(e);
    endtask

    task automatic bubble(input string tag);
        ent_t e;
        e.v = 0; e.w = '0; e.tag = tag;
        wq.push_back(e);
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (run) begin
            bit e0v, e1v, eh, nh_v, nl_v, nl_fp, stalled;
            logic [31:0] e0, e1, up, lo, nh;
            int nl_r;
            string tg;
            up = fetch_word[63:32]; lo = fetch_word[31:0];
            e0v = 0; e1v = 0; eh = 0; e0 = up; e1 = lo; stalled = 0;
            nh_v = mh_v; nh = mh; nl_v = 0; nl_r = 0; nl_fp = 0;
            tg = cur_tag;
            if (mh_v) begin
                eh = 1; e0 = mh; tg = "R8";
                if (!(ml_v && reads(mh, ml_r, ml_fp))) begin
                    e0v = 1; nh_v = 0;
                    if (is_ld(mh)) begin nl_v = 1; nl_r = mh[20:16]; nl_fp = (mh[31:26] == 6'h31); end
                end
            end else if (fetch_valid) begin
                if (ml_v && reads(up, ml_r, ml_fp)) begin
                    eh = 1; stalled = 1; tg = "R9";
                end else begin
                    bit same;
                    e0v = 1;
                    same = 0;
                    if (is_ld(up)) begin
                        nl_v = 1; nl_r = up[20:16]; nl_fp = (up[31:26] == 6'h31);
                        same = reads(lo, nl_r, nl_fp);
                    end
                    if (!is_fpop(up) && is_fpop(lo) && !same && !(ml_v && reads(lo, ml_r, ml_fp)))
                        e1v = 1;
                    else begin nh_v = 1; nh = lo; end
                end
            end
            chk(tg, "issue0_vld", {31'b0, issue0_vld}, {31'b0, e0v});
            chk(tg, "issue1_vld", {31'b0, issue1_vld}, {31'b0, e1v});
            chk(tg, "fetch_hold", {31'b0, fetch_hold}, {31'b0, eh});
            if (e0v) chk(tg, "issue0_instr", issue0_instr, e0);
            if (e1v) chk(tg, "issue1_instr", issue1_instr, e1);
            if (issue1_vld && !issue0_vld) chk("R4", "slot1 without slot0", 32'd1, 32'd0);
            if (stalled && issue1_vld) chk("R9", "slot1 during stall", 32'd1, 32'd0);
            mh_v = nh_v; mh = nh; ml_v = nl_v; ml_r = nl_r; ml_fp = nl_fp;
            // advance stimulus queue
            if (wq.size() > 0) begin
                if (!wq[0].v) void'(wq.pop_front());
                else if (fetch_valid && !eh) void'(wq.pop_front());
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [5:0] ops [6];
        ops[0] = 6'h00; ops[1] = 6'h23; ops[2] = 6'h31; ops[3] = 6'h2B; ops[4] = 6'h39; ops[5] = 6'h11;

        // R3 independent legal pair
        push(mk(6'h00, 1, 2), mk(6'h11, 3, 4), "R3");
        // R10 int load r5, FP op reads f5: no collision
        push(mk(6'h23, 9, 5), mk(6'h11, 5, 5), "R10");
        push(mk(6'h00, 1, 2), mk(6'h11, 5, 5), "R10");
        // R6 FP load f6 feeding FP op beside it -> parked
        push(mk(6'h31, 1, 6), mk(6'h11, 6, 2), "R6");
        // R6 FP load with independent FP op pairs
        push(mk(6'h31, 1, 7), mk(6'h11, 1, 2), "R6");
        // R7/R9 int load r8, next left reads r8 -> stall
        push(mk(6'h23, 1, 8), mk(6'h11, 1, 2), "R7");
        push(mk(6'h00, 8, 3), mk(6'h11, 3, 4), "R9");
        // R7 next right reads loaded f9 -> parked
        push(mk(6'h31, 2, 9), mk(6'h11, 1, 1), "R7");
        push(mk(6'h00, 1, 2), mk(6'h11, 9, 3), "R7");
        // R5 misplaced classes
        push(mk(6'h11, 1, 2), mk(6'h11, 3, 4), "R5");
        push(mk(6'h00, 1, 2), mk(6'h00, 3, 4), "R5");
        // R11 idle cycle ends the delay
        push(mk(6'h23, 1, 10), mk(6'h11, 1, 2), "R11");
        bubble("R11");
        push(mk(6'h00, 10, 10), mk(6'h11, 1, 2), "R11");
        // R2 stores: FP store data reads f12 after FP load f12; int store with r12 is free
        push(mk(6'h31, 1, 12), mk(6'h11, 1, 2), "R2");
        push(mk(6'h2B, 3, 12), mk(6'h11, 3, 3), "R2");
        push(mk(6'h31, 1, 12), mk(6'h11, 1, 2), "R2");
        push(mk(6'h39, 3, 12), mk(6'h11, 3, 3), "R2");
        bubble("R1");
        // pseudo-random stream
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = mk(ops[lfsr[7:0] % 6], lfsr[9:8], lfsr[11:10]);
            b = mk((lfsr[13:12] != 0) ? 6'h11 : ops[lfsr[17:14] % 6], lfsr[19:18], lfsr[21:20]);
            if (lfsr[26:24] == 0) bubble("R3");
            push(a, b, "R3");
        end

        // R1 reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "issue0_vld", {31'b0, issue0_vld}, 32'd0);
        chk("R1", "issue1_vld", {31'b0, issue1_vld}, 32'd0);
        chk("R1", "fetch_hold", {31'b0, fetch_hold}, 32'd0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk("R1", "idle fetch_hold", {31'b0, fetch_hold}, 32'd0);
        chk("R1", "idle issue0_vld", {31'b0, issue0_vld}, 32'd0);
        run = 1;

        while (wq.size() > 0) begin
            @(posedge clk); #1;
            if (wq.size() > 0) begin
                fetch_valid = wq[0].v;
                fetch_word  = wq[0].w;
                cur_tag     = wq[0].tag;
            end else fetch_valid = 0;
        end
        @(posedge clk); #1 fetch_valid = 0; cur_tag = "R1";
        repeat (6) @(posedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule